// File: doc/BRIEF.md
# USB Device Interrupt Status Controller

This block collects the event pulses of a full-speed USB device controller with six endpoints and turns them into one level-sensitive interrupt line for the CPU. Other blocks raise single-cycle pulses for bus events (suspend or resume), attach/detach changes, wakeup, per-endpoint transaction completions, NAK replies to IN tokens and setup packets. Each pulse sets a sticky status flag. Software clears a flag by writing 1 to its bit.

A second register holds the interrupt enables for the four event classes, plus two gates. One gate lets wakeup events reach their flag. The other lets NAK-on-IN replies count as endpoint events. The endpoint and setup flags have no enables of their own. They feed the interrupt through the USB-event class. Writing 1 to the USB-event summary bit also clears every endpoint flag. This lets a handler acknowledge a whole round of endpoint traffic with one write.

Software reaches both registers through a plain port. The port has a write strobe with a register select and a separate combinational read select.

Top module: `usbd_irq_ctrl`

## Requirements
- R1: After reset, the status register, the enable register and `irq` are all 0.
- R2: Each flag is set by its pulse in the clock edge where the pulse is sampled, and then stays set. The status register layout is: bit 0 is the bus event, bit 2 is attach/detach, bit 3 is wakeup, bits 16+i are endpoint i (i = 0..5) and bit 31 is setup. All other bits read 0.
- R3: A status write (`wr_sel`=0) clears each flag whose `wr_data` bit is 1. A 0 bit leaves its flag unchanged.
- R4: Writing 1 to status bit 1 clears bit 1 and all of bits 16..21. Writing 1 to a single endpoint bit clears only that endpoint flag.
- R5: An endpoint transaction pulse (`ev_ep[i]`) or a setup pulse sets the USB-event summary bit 1, together with its own flag.
- R6: A NAK-on-IN pulse (`ev_in_nak[i]`) sets endpoint flag i and bit 1 only while enable bit 15 is 1. Otherwise it changes nothing.
- R7: A wakeup pulse sets status bit 3 only while enable bit 8 is 1.
- R8: An enable write (`wr_sel`=1) loads only enable bits 0 (bus), 1 (USB), 2 (attach), 3 (wakeup), 8 (wakeup gate) and 15 (NAK gate). Every other enable bit reads 0.
- R9: `irq` is 1 exactly when an enabled class has a pending flag. The classes are: bus (status 0, enable 0); USB (status 1, or any of 16..21, or 31, with enable 1); attach (status 2, enable 2); wakeup (status 3, enable 3).
- R10: If a pulse arrives in the same cycle as a write-1 clear of its flag, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 status, 1 enable |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read source: 0 status, 1 enable |
| rd_data | output | 32 | Selected register contents, combinational |
| ev_bus | input | 1 | Bus event pulse |
| ev_attach | input | 1 | Attach/detach change pulse |
| ev_wakeup | input | 1 | Wakeup pulse |
| ev_ep | input | 6 | Per-endpoint transaction completion pulses |
| ev_in_nak | input | 6 | Per-endpoint NAK-on-IN pulses |
| ev_setup | input | 1 | Setup packet pulse |
| irq | output | 1 | Interrupt request |

## Verification
A pulse or write presented in one cycle updates the registers at the next rising edge. From that edge, `rd_data` and `irq` show the new state combinationally, so every result is due one edge after its stimulus. The bench drives each stimulus just after a falling edge and advances a reference model at the rising edge. It then compares both register reads and `irq` at the next falling edge, with the read select stepped while the clock is low. A pulse is removed at that same falling edge, so each stimulus acts on exactly one edge.

// File: rtl/usbd_irq_ctrl.sv
module usbd_irq_ctrl #(
  parameter int NUM_EP    = 6,
  parameter int EP_LSB    = 16,
  parameter int SETUP_BIT = 31,
  parameter int DW        = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DW-1:0]     wr_data,
  input  logic              rd_sel,
  output logic [DW-1:0]     rd_data,
  input  logic              ev_bus,
  input  logic              ev_attach,
  input  logic              ev_wakeup,
  input  logic [NUM_EP-1:0] ev_ep,
  input  logic [NUM_EP-1:0] ev_in_nak,
  input  logic              ev_setup,
  output logic              irq
);
  localparam logic [DW-1:0] ONE      = {{(DW-1){1'b0}}, 1'b1};
  localparam logic [DW-1:0] EP_MASK  = ((ONE << NUM_EP) - ONE) << EP_LSB;
  localparam logic [DW-1:0] STS_MASK = EP_MASK | (ONE << SETUP_BIT) | ((ONE << 4) - ONE);
  localparam int            WAKE_GATE = 8;
  localparam int            NAK_GATE  = 15;
  localparam logic [DW-1:0] EN_MASK  = ((ONE << 4) - ONE) | (ONE << WAKE_GATE) | (ONE << NAK_GATE);

  logic [DW-1:0]     sts_q, en_q;
  logic [DW-1:0]     sts_set, sts_clr;
  logic [NUM_EP-1:0] ep_hit;
  logic              usb_pend;

  assign ep_hit = ev_ep | (ev_in_nak & {NUM_EP{en_q[NAK_GATE]}});

  always_comb begin
    sts_set = '0;
    sts_set[0] = ev_bus;
    sts_set[1] = (|ep_hit) | ev_setup;
    sts_set[2] = ev_attach;
    sts_set[3] = ev_wakeup & en_q[WAKE_GATE];
    sts_set[EP_LSB +: NUM_EP] = ep_hit;
    sts_set[SETUP_BIT] = ev_setup;
  end

  always_comb begin
    sts_clr = '0;
    if (wr_en && !wr_sel) begin
      sts_clr = wr_data & STS_MASK;
      if (wr_data[1]) sts_clr = sts_clr | EP_MASK;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_q <= '0;
      en_q  <= '0;
    end else begin
      sts_q <= (sts_q & ~sts_clr) | sts_set;
      if (wr_en && wr_sel) en_q <= wr_data & EN_MASK;
    end
  end

  assign usb_pend = sts_q[1] | (|sts_q[EP_LSB +: NUM_EP]) | sts_q[SETUP_BIT];
  assign irq      = |(en_q[3:0] & {sts_q[3], sts_q[2], usb_pend, sts_q[0]});
  assign rd_data  = rd_sel ? en_q : sts_q;
endmodule

// File: rtl/usbd_irq_ctrl_chk.sv
module usbd_irq_ctrl_chk #(
  parameter int NUM_EP = 6,
  parameter int EP_LSB = 16,
  parameter int DW     = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              wr_sel,
  input logic [DW-1:0]     wr_data,
  input logic              ev_attach,
  input logic              ev_wakeup,
  input logic [NUM_EP-1:0] ev_ep,
  input logic [NUM_EP-1:0] ev_in_nak,
  input logic              ev_setup,
  input logic              irq,
  input logic [DW-1:0]     sts_q,
  input logic [DW-1:0]     en_q
);
  // R2
  sticky_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q[0] && !(wr_en && !wr_sel && wr_data[0])) |=> sts_q[0]);
  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_attach |=> sts_q[2]);
  // R4
  usb_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel && wr_data[1] && ev_ep == '0 && ev_in_nak == '0)
      |=> sts_q[EP_LSB +: NUM_EP] == '0);
  // R5
  ep_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ep != '0 || ev_setup) |=> sts_q[1]);
  // R6
  nak_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_in_nak != '0 && !en_q[15] && ev_ep == '0 && !ev_setup && !wr_en)
      |=> ($stable(sts_q[EP_LSB +: NUM_EP]) && $stable(sts_q[1])));
  // R7
  wake_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wakeup && !en_q[8] && !sts_q[3]) |=> !sts_q[3]);
  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q[3:0] == 4'b0) |-> !irq);
endmodule

bind usbd_irq_ctrl usbd_irq_ctrl_chk #(.NUM_EP(NUM_EP), .EP_LSB(EP_LSB), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .ev_attach(ev_attach), .ev_wakeup(ev_wakeup), .ev_ep(ev_ep), .ev_in_nak(ev_in_nak),
  .ev_setup(ev_setup), .irq(irq), .sts_q(sts_q), .en_q(en_q)
);

// File: tb/test_usbd_irq_ctrl.sv
`timescale 1ns/1ps
module test_usbd_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        ev_bus = 1'b0, ev_attach = 1'b0, ev_wakeup = 1'b0, ev_setup = 1'b0;
  logic [5:0]  ev_ep = '0, ev_in_nak = '0;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  logic [31:0] m_sts = '0, m_en = '0;

  always #4 clk = ~clk;

  usbd_irq_ctrl i_usbd_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .ev_bus(ev_bus), .ev_attach(ev_attach),
    .ev_wakeup(ev_wakeup), .ev_ep(ev_ep), .ev_in_nak(ev_in_nak), .ev_setup(ev_setup),
    .irq(irq)
  );

  function automatic logic [31:0] nxt_sts(input logic [31:0] s, input logic [31:0] e);
    logic [31:0] set, clr;
    logic [5:0]  hit;
    hit = ev_ep | (e[15] ? ev_in_nak : 6'b0);
    set = '0;
    set[0] = ev_bus;
    set[1] = (|hit) | ev_setup;
    set[2] = ev_attach;
    set[3] = ev_wakeup & e[8];
    set[21:16] = hit;
    set[31] = ev_setup;
    clr = '0;
    if (wr_en && !wr_sel) begin
      clr = wr_data & 32'h803F_000F;
      if (wr_data[1]) clr[21:16] = 6'h3F;
    end
    return (s & ~clr) | set;
  endfunction

  function automatic logic [31:0] nxt_en(input logic [31:0] e);
    return (wr_en && wr_sel) ? (wr_data & 32'h0000_810F) : e;
  endfunction

  function automatic logic exp_irq(input logic [31:0] s, input logic [31:0] e);
    logic usb;
    usb = s[1] | (|s[21:16]) | s[31];
    return |(e[3:0] & {s[3], s[2], usb, s[0]});
  endfunction

  task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    rd_sel = 1'b0; #1;
    cmp(tag, "status", rd_data, m_sts);
    rd_sel = 1'b1; #1;
    cmp(tag, "enable", rd_data, m_en);
    cmp((tag == "R1") ? "R1" : "R9", "irq", {31'b0, irq}, {31'b0, exp_irq(m_sts, m_en)});
  endtask

  task automatic tick(input string tag);
    logic [31:0] ns, ne;
    ns = nxt_sts(m_sts, m_en);
    ne = nxt_en(m_en);
    @(posedge clk);
    m_sts = ns;
    m_en  = ne;
    @(negedge clk);
    wr_en = 1'b0; ev_bus = 1'b0; ev_attach = 1'b0; ev_wakeup = 1'b0;
    ev_setup = 1'b0; ev_ep = '0; ev_in_nak = '0;
    check_all(tag);
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_all("R1");
    // R8: only the defined enable bits stick
    wr(1'b1, 32'hFFFF_FFFF); tick("R8");
    wr(1'b1, 32'h0000_000F); tick("R8");
    // R2: bus pulse sets bit 0 and stays
    ev_bus = 1'b1; tick("R2");
    tick("R2");
    // R3: writing zeros changes nothing, writing 1 clears
    wr(1'b0, 32'h0); tick("R3");
    wr(1'b0, 32'h1); tick("R3");
    // R5: endpoint and setup pulses set summary
    ev_ep = 6'b000100; tick("R5");
    ev_setup = 1'b1; tick("R5");
    // R4: summary clear wipes endpoints, setup stays
    ev_ep = 6'b000011; tick("R4");
    wr(1'b0, 32'h0000_0002); tick("R4");
    ev_ep = 6'b000011; tick("R4");
    wr(1'b0, 32'h0001_0000); tick("R4");
    wr(1'b0, 32'h8002_0002); tick("R4");
    // R6: NAK gated by enable bit 15
    ev_in_nak = 6'b100000; tick("R6");
    wr(1'b1, 32'h0000_810F); tick("R6");
    ev_in_nak = 6'b100000; tick("R6");
    wr(1'b0, 32'h0000_0002); tick("R6");
    // R7: wakeup gated by enable bit 8
    wr(1'b1, 32'h0000_000F); tick("R7");
    ev_wakeup = 1'b1; tick("R7");
    wr(1'b1, 32'h0000_010F); tick("R7");
    ev_wakeup = 1'b1; tick("R7");
    // R10: pulse and clear together
    ev_attach = 1'b1; tick("R10");
    ev_attach = 1'b1; wr(1'b0, 32'h0000_0004); tick("R10");
    ev_ep = 6'b000001; wr(1'b0, 32'h0000_0002); tick("R10");
    // random mix, checked against the model (R2 R3 R8 R9)
    for (int i = 0; i < 4000; i++) begin
      ev_bus    = ($urandom_range(0, 15) == 0);
      ev_attach = ($urandom_range(0, 15) == 0);
      ev_wakeup = ($urandom_range(0, 15) == 0);
      ev_setup  = ($urandom_range(0, 31) == 0);
      ev_ep     = ($urandom_range(0, 3) == 0) ? 6'($urandom) & 6'($urandom) : 6'b0;
      ev_in_nak = ($urandom_range(0, 3) == 0) ? 6'($urandom) & 6'($urandom) : 6'b0;
      if ($urandom_range(0, 3) == 0) begin
        wr_en = 1'b1;
        wr_sel = ($urandom_range(0, 4) == 0);
        wr_data = $urandom & $urandom;
      end
      tick("R2");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule